// File: doc/BRIEF.md
# OTG Session Timeout Timer

This block is a one-shot timeout timer that software arms and cancels through a single 32-bit control word. Bit 31 of the word is the arm flag and bits 26:0 hold a tick count measured in cycles of the 60 MHz device clock on which the block runs. When software writes the word with the arm flag set, the counter starts. When the count runs out, the block clears the stored word to zero and sends a single-cycle request to the interrupt collector, which owns the timeout bit (bit 16 of its source word).

Software can overwrite the word at any time. A write with the arm flag set restarts the timer with the new count. A write with the arm flag clear stops it, and no request is made. Reading the word returns the last written value until the timer expires, and zero after that. Bits 30:27 are kept as written but have no effect on timing.

Top module: `otg_timeout_timer`

## Requirements
- R1: After reset, `rd_data_o` reads 0 and `timeout_o` is low.
- R2: A write (`wr_en_i` high at a rising edge) stores all 32 bits of `wr_data_i`, and `rd_data_o` shows them from the following cycle, bits 30:27 included.
- R3: A write with bit 31 set and count N in bits 26:0 drives `timeout_o` high for exactly one cycle, directly after the (N+1)-th rising edge that follows the write edge, and not earlier. The value of bits 30:27 does not change this timing.
- R4: In the cycle where `timeout_o` is high, `rd_data_o` reads 0, and it stays 0 until the next write.
- R5: A write with bit 31 clear cancels a running timeout. No pulse follows, and `rd_data_o` keeps the written word.
- R6: A write with bit 31 set while the timer is running restarts it. The timing of R3 is then measured from the new write, and the earlier count never fires.
- R7: A write with bit 31 set and a count of 0 expires on the next rising edge, so `timeout_o` is high in the cycle after that edge.
- R8: A write that lands on the same edge as an expiry takes priority. The expiry is dropped, so no pulse occurs, and the written word is stored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | 60 MHz device clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Write strobe for the control word |
| wr_data_i | input | 32 | Control word: bit 31 is the arm flag, bits 26:0 are the count |
| rd_data_o | output | 32 | Stored control word (zero after expiry) |
| timeout_o | output | 1 | One-cycle timeout request to the interrupt collector |

## Verification
The hardest case to reach is a write that lands on exactly the edge where the timer would expire. The bench arms a short count and counts the falling edges that follow. It then drives the next write so that the write is sampled on the expiry edge itself, once as a cancelling word and once as a restart. Restart partway through a count and cancel partway through a count are driven the same way, at chosen edge offsets. The bench then watches for the original pulse both at its original time and at the new time.

// File: rtl/otg_tmr_pkg.sv
package otg_tmr_pkg;
  parameter int unsigned WORD_W  = 32;
  parameter int unsigned TICK_W  = 27;
  parameter int unsigned ARM_POS = 31;
endpackage

// File: rtl/otg_tmr_count.sv
module otg_tmr_count #(
  parameter int unsigned TICK_W = otg_tmr_pkg::TICK_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              arm_i,
  input  logic [TICK_W-1:0] ticks_i,
  output logic              expire_o
);
  logic              run_q, run_d;
  logic [TICK_W-1:0] cnt_q, cnt_d;
  logic              cnt_en;
  logic              at_zero;

  assign at_zero = (cnt_q == '0);

  always_comb begin
    run_d    = run_q;
    cnt_d    = cnt_q;
    cnt_en   = 1'b0;
    expire_o = 1'b0;
    if (load_i) begin
      run_d  = arm_i;
      cnt_d  = ticks_i;
      cnt_en = 1'b1;
    end else if (run_q) begin
      if (at_zero) begin
        run_d    = 1'b0;
        expire_o = 1'b1;
      end else begin
        cnt_d  = cnt_q - 1'b1;
        cnt_en = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      run_q <= run_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  // R3: a running count above zero steps down by one when no write occurs
  p_count_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && !at_zero && !load_i) |=> (run_q && cnt_q == $past(cnt_q) - 1'b1));

  // R5: a write with the arm flag clear stops the counter
  p_cancel_stops_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !arm_i) |=> !run_q);

  // R6: an armed write (re)starts the counter with its new count
  p_restart_loads_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && arm_i) |=> (run_q && cnt_q == $past(ticks_i)));

  // R8: a write on the expiry edge suppresses the expiry
  p_write_wins_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> !expire_o);
endmodule

// File: rtl/otg_tmr_word.sv
module otg_tmr_word #(
  parameter int unsigned WORD_W = otg_tmr_pkg::WORD_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [WORD_W-1:0] wr_data_i,
  input  logic              clear_i,
  output logic [WORD_W-1:0] word_o
);
  logic [WORD_W-1:0] word_q, word_d;
  logic              word_en;

  always_comb begin
    word_d  = word_q;
    word_en = 1'b0;
    if (wr_en_i) begin
      word_d  = wr_data_i;
      word_en = 1'b1;
    end else if (clear_i) begin
      word_d  = '0;
      word_en = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) word_q <= '0;
    else if (word_en) word_q <= word_d;
  end

  assign word_o = word_q;

  // R2: the written word is stored in full
  p_write_stores_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> (word_q == $past(wr_data_i)));

  // R4: expiry without a write zeroes the stored word
  p_expiry_clears_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clear_i && !wr_en_i) |=> (word_q == '0));
endmodule

// File: rtl/otg_tmr_pulse.sv
module otg_tmr_pulse (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fire_i,
  output logic pulse_o
);
  logic pulse_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pulse_q <= 1'b0;
    else         pulse_q <= fire_i;
  end

  assign pulse_o = pulse_q;

  // R3: the timeout request lasts a single cycle
  p_single_cycle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_q |=> !pulse_q);
endmodule

// File: rtl/otg_timeout_timer.sv
module otg_timeout_timer #(
  parameter int unsigned WORD_W  = otg_tmr_pkg::WORD_W,
  parameter int unsigned TICK_W  = otg_tmr_pkg::TICK_W,
  parameter int unsigned ARM_POS = otg_tmr_pkg::ARM_POS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [WORD_W-1:0] wr_data_i,
  output logic [WORD_W-1:0] rd_data_o,
  output logic              timeout_o
);
  localparam int unsigned SYNC_D = 2;

  logic [SYNC_D-1:0] rst_sync_q;
  logic              rst_n;
  logic              expire;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= '0;
    else         rst_sync_q <= {rst_sync_q[SYNC_D-2:0], 1'b1};
  end
  assign rst_n = rst_sync_q[SYNC_D-1];

  otg_tmr_count #(.TICK_W(TICK_W)) count_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_n),
    .load_i   (wr_en_i),
    .arm_i    (wr_data_i[ARM_POS]),
    .ticks_i  (wr_data_i[TICK_W-1:0]),
    .expire_o (expire)
  );

  otg_tmr_word #(.WORD_W(WORD_W)) word_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_n),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .clear_i   (expire),
    .word_o    (rd_data_o)
  );

  otg_tmr_pulse pulse_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_n),
    .fire_i  (expire),
    .pulse_o (timeout_o)
  );

  // R4: the request and the zeroed word appear together
  p_pulse_word_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_n)
    timeout_o |-> (rd_data_o == '0));

  // R1: outputs are idle while reset is held
  always_comb begin
    if (!rst_n) begin
      p_reset_idle_r1: assert (!timeout_o && rd_data_o == '0);
    end
  end
endmodule

// File: tb/otg_timeout_timer_tb.sv
module otg_timeout_timer_tb_top;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        tmo;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  otg_timeout_timer dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .rd_data_o(rd_data), .timeout_o(tmo)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Called at a falling edge; the write is sampled at the next rising edge
  // and the task returns at the falling edge right after it.
  task automatic do_write(input logic [31:0] d);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  // Called right after do_write; expects the pulse after the (n+1)-th edge.
  task automatic expect_pulse(input int n, input string req);
    bit early = 1'b0;
    if (tmo) early = 1'b1;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (tmo) early = 1'b1;
    end
    check(!early, req, "no early pulse", {31'b0, early}, 32'h0);
    @(negedge clk);
    check(tmo === 1'b1, req, "pulse at count end", {31'b0, tmo}, 32'h1);
    check(rd_data === 32'h0, "R4", "word zero with pulse", rd_data, 32'h0);
    @(negedge clk);
    check(tmo === 1'b0, req, "pulse one cycle", {31'b0, tmo}, 32'h0);
    check(rd_data === 32'h0, "R4", "word stays zero", rd_data, 32'h0);
  endtask

  task automatic expect_quiet(input int n, input logic [31:0] word, input string req);
    bit seen = 1'b0;
    for (int k = 0; k < n; k++) begin
      if (tmo) seen = 1'b1;
      @(negedge clk);
    end
    check(!seen, req, "no pulse", {31'b0, seen}, 32'h0);
    check(rd_data === word, req, "word held", rd_data, word);
  endtask

  task automatic t_reset;
    check(rd_data === 32'h0, "R1", "reset word", rd_data, 32'h0);
    check(tmo === 1'b0, "R1", "reset pulse", {31'b0, tmo}, 32'h0);
  endtask

  task automatic t_store_disarmed;
    do_write(32'h7ABC_1234);
    check(rd_data === 32'h7ABC_1234, "R2", "stored word", rd_data, 32'h7ABC_1234);
    expect_quiet(30, 32'h7ABC_1234, "R5");
  endtask

  task automatic t_basic_expire;
    do_write(32'hF800_0005);
    check(rd_data === 32'hF800_0005, "R2", "armed word readback", rd_data, 32'hF800_0005);
    expect_pulse(5, "R3");
    do_write(32'h8000_0005);
    expect_pulse(5, "R3");
    do_write(32'h8000_0040);
    expect_pulse(64, "R3");
  endtask

  task automatic t_zero_count;
    do_write(32'h8000_0000);
    expect_pulse(0, "R7");
  endtask

  task automatic t_cancel;
    do_write(32'h8000_000A);
    repeat (3) @(negedge clk);
    do_write(32'h0000_0055);
    expect_quiet(30, 32'h0000_0055, "R5");
  endtask

  task automatic t_restart;
    do_write(32'h8000_0004);
    repeat (2) @(negedge clk);
    do_write(32'h8000_0006);
    expect_pulse(6, "R6");
  endtask

  task automatic t_collide;
    // count 2: expiry edge is the third edge after the write edge
    do_write(32'h8000_0002);
    repeat (2) @(negedge clk);
    do_write(32'h0000_0033);
    expect_quiet(20, 32'h0000_0033, "R8");
    do_write(32'h8000_0002);
    repeat (2) @(negedge clk);
    do_write(32'h8000_0003);
    expect_pulse(3, "R8");
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset;
    t_store_disarmed;
    t_basic_expire;
    t_zero_count;
    t_cancel;
    t_restart;
    t_collide;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule